// File: doc/BRIEF.md
# Indexed Interrupt Priority Level Bank

This block is a single 16-bit register through which software reaches a whole bank of per-interrupt priority levels. The upper byte of the register is a pointer. The low three bits are a window onto the level entry that the pointer currently names. Reads return the pointer together with the selected level. Writes can move the pointer, update the selected level, or do both in one access.

When software writes the full word, the new pointer value chooses the entry that receives the new level. This lets one access retarget the window and program a level. Interrupt numbers below a fixed base have hard-wired priority and no storage. Numbers above a configurable top interrupt number do not exist. For both groups, level writes are dropped and the level field reads back as zero.

Every stored level is also driven in parallel on a flat vector, so that a neighbouring priority arbiter can use all of them at once.

Top module: `irq_level_bank`

## Requirements
- R1: After reset the pointer is 0, every stored level is 3'b111, and the read word is 16'h0000.
- R2: A write with only the upper byte enabled (`bus_be` = 2'b10) loads `bus_wdata[15:8]` into the pointer and changes no level.
- R3: A write with only the lower byte enabled (`bus_be` = 2'b01) stores `bus_wdata[2:0]` into the entry named by the current pointer, when that pointer lies in 12..MAX_IRQ. The pointer does not change.
- R4: A word write (`bus_be` = 2'b11) stores `bus_wdata[2:0]` into the entry named by `bus_wdata[15:8]` and loads that value into the pointer in the same cycle.
- R5: A level write whose target index is below 12 changes no stored level.
- R6: A level write whose target index is above MAX_IRQ changes no stored level.
- R7: `bus_rdata[15:8]` always shows the pointer. `bus_rdata[2:0]` shows the entry the pointer names, or 3'b000 when the pointer is outside 12..MAX_IRQ.
- R8: `bus_rdata[7:3]` always reads zero. Data on `bus_wdata[7:3]` has no effect.
- R9: `levels_flat[3n+2:3n]` carries the level of interrupt n for n in 12..MAX_IRQ. The slices for n below 12 are zero.
- R10: A cycle with `bus_sel` low, or with `bus_wr` low, or with `bus_be` = 2'b00 changes neither the pointer nor any level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access to the register in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_be | input | 2 | Byte enables: bit 1 = upper byte, bit 0 = lower byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read word: pointer, zeros, selected level |
| levels_flat | output | (MAX_IRQ+1)*3 | All levels, 3 bits per interrupt number |

## Verification
The properties assume that the bus inputs are known (not X) whenever `bus_sel` is high. They also assume that `bus_be`, `bus_wr` and `bus_wdata` hold steady around the rising edge.

The bench changes inputs only on the falling edge and always drives defined values, including when `bus_sel` is low.

Both directed and random accesses reach pointer values across the whole 8-bit range, including 11, 12, MAX_IRQ, MAX_IRQ+1 and 255. This exercises the protected regions of the read path as well as the write path.

// File: rtl/irq_lvl_pkg.sv
package irq_lvl_pkg;

   localparam int REG_W      = 16;
   localparam int BE_W       = REG_W / 8;
   localparam int DEF_IDX_W  = 8;
   localparam int DEF_LVL_W  = 3;
   localparam int DEF_FIRST  = 12;
   localparam int DEF_MAX    = 63;

   typedef enum logic [1:0] {
      ACC_NONE  = 2'b00,
      ACC_LOW   = 2'b01,
      ACC_HIGH  = 2'b10,
      ACC_WORD  = 2'b11
   } acc_kind_e;

   function automatic acc_kind_e classify(input logic sel, input logic wr,
                                          input logic [BE_W-1:0] be);
      if (!(sel && wr)) return ACC_NONE;
      return acc_kind_e'(be);
   endfunction

endpackage

// File: rtl/irq_lvl_ptr.sv
module irq_lvl_ptr #(
   parameter int IDX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [IDX_W-1:0] din,
   output logic [IDX_W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q <= '0;
      else if (load) q <= din;
   end

endmodule

// File: rtl/irq_lvl_wdec.sv
module irq_lvl_wdec
   import irq_lvl_pkg::*;
#(
   parameter int IDX_W   = 8,
   parameter int FIRST   = 12,
   parameter int MAX_IRQ = 63,
   localparam int NSLOT  = MAX_IRQ - FIRST + 1
) (
   input  logic             acc_sel,
   input  logic             acc_wr,
   input  logic [BE_W-1:0]  acc_be,
   input  logic [IDX_W-1:0] new_idx,
   input  logic [IDX_W-1:0] cur_idx,
   output logic             ptr_load,
   output logic [NSLOT-1:0] slot_we
);

   acc_kind_e        kind;
   logic [IDX_W-1:0] tgt;
   logic             lvl_req;

   always_comb begin
      kind     = classify(acc_sel, acc_wr, acc_be);
      ptr_load = (kind == ACC_HIGH) || (kind == ACC_WORD);
      lvl_req  = (kind == ACC_LOW)  || (kind == ACC_WORD);
      tgt      = (kind == ACC_WORD) ? new_idx : cur_idx;
   end

   for (genvar s = 0; s < NSLOT; s++) begin : g_sel
      assign slot_we[s] = lvl_req && (tgt == IDX_W'(FIRST + s));
   end

endmodule

// File: rtl/irq_lvl_slots.sv
module irq_lvl_slots #(
   parameter int LVL_W    = 3,
   parameter int NSLOT    = 52,
   parameter int RST_LVL  = 7,
   localparam int FLAT_W  = NSLOT * LVL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSLOT-1:0]  slot_we,
   input  logic [LVL_W-1:0]  wlvl,
   output logic [FLAT_W-1:0] slots_flat
);

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      logic [LVL_W-1:0] lvl_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          lvl_q <= LVL_W'(RST_LVL);
         else if (slot_we[s]) lvl_q <= wlvl;
      end
      assign slots_flat[s*LVL_W +: LVL_W] = lvl_q;
   end

endmodule

// File: rtl/irq_level_bank.sv
module irq_level_bank
   import irq_lvl_pkg::*;
#(
   parameter int IDX_W    = DEF_IDX_W,
   parameter int LVL_W    = DEF_LVL_W,
   parameter int FIRST    = DEF_FIRST,
   parameter int MAX_IRQ  = DEF_MAX,
   parameter int RST_LVL  = 7,
   localparam int NSLOT   = MAX_IRQ - FIRST + 1,
   localparam int OUT_W   = (MAX_IRQ + 1) * LVL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [BE_W-1:0]   bus_be,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic [OUT_W-1:0]  levels_flat
);

   // elaboration-time parameter checks
   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("IDX_W must be 1..8");
   end
   if (LVL_W < 1 || LVL_W > 8) begin : g_bad_lvl
      $error("LVL_W must be 1..8");
   end
   if (MAX_IRQ < FIRST) begin : g_bad_range
      $error("MAX_IRQ must not be below FIRST");
   end
   if (MAX_IRQ >= (1 << IDX_W)) begin : g_bad_max
      $error("MAX_IRQ does not fit the pointer");
   end
   if (RST_LVL >= (1 << LVL_W)) begin : g_bad_rst
      $error("RST_LVL does not fit a level");
   end

   logic [IDX_W-1:0]       cur_idx;
   logic [IDX_W-1:0]       new_idx;
   logic [LVL_W-1:0]       new_lvl;
   logic                   ptr_load;
   logic [NSLOT-1:0]       slot_we;
   logic [NSLOT*LVL_W-1:0] slots_flat;
   logic [LVL_W-1:0]       rd_lvl;

   assign new_idx = bus_wdata[REG_W-1 -: IDX_W];
   assign new_lvl = bus_wdata[LVL_W-1:0];

   irq_lvl_ptr #(.IDX_W(IDX_W)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ptr_load),
      .din   (new_idx),
      .q     (cur_idx)
   );

   irq_lvl_wdec #(.IDX_W(IDX_W), .FIRST(FIRST), .MAX_IRQ(MAX_IRQ)) u_wdec (
      .acc_sel  (bus_sel),
      .acc_wr   (bus_wr),
      .acc_be   (bus_be),
      .new_idx  (new_idx),
      .cur_idx  (cur_idx),
      .ptr_load (ptr_load),
      .slot_we  (slot_we)
   );

   irq_lvl_slots #(.LVL_W(LVL_W), .NSLOT(NSLOT), .RST_LVL(RST_LVL)) u_slots (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_we    (slot_we),
      .wlvl       (new_lvl),
      .slots_flat (slots_flat)
   );

   // readback: OR of matched slots, zero when pointer is outside the window
   always_comb begin
      rd_lvl = '0;
      for (int s = 0; s < NSLOT; s++) begin
         if (cur_idx == IDX_W'(FIRST + s))
            rd_lvl = rd_lvl | slots_flat[s*LVL_W +: LVL_W];
      end
   end

   always_comb begin
      bus_rdata = '0;
      bus_rdata[REG_W-1 -: IDX_W] = cur_idx;
      bus_rdata[LVL_W-1:0]        = rd_lvl;
   end

   // parallel export: fixed-priority numbers carry zero
   for (genvar n = 0; n <= MAX_IRQ; n++) begin : g_out
      if (n < FIRST) begin : g_fixed
         assign levels_flat[n*LVL_W +: LVL_W] = '0;
      end else begin : g_live
         assign levels_flat[n*LVL_W +: LVL_W] = slots_flat[(n-FIRST)*LVL_W +: LVL_W];
      end
   end

endmodule

// File: rtl/irq_level_bank_chk.sv
module irq_level_bank_chk #(
   parameter int IDX_W   = 8,
   parameter int LVL_W   = 3,
   parameter int FIRST   = 12,
   parameter int MAX_IRQ = 63,
   localparam int OUT_W  = (MAX_IRQ + 1) * LVL_W
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic [1:0]       bus_be,
   input logic [15:0]      bus_wdata,
   input logic [15:0]      bus_rdata,
   input logic [OUT_W-1:0] levels_flat
);

   logic [IDX_W-1:0] ptr;
   logic [IDX_W-1:0] tgt;
   logic             lvl_write;
   logic             ptr_in_win;
   logic             tgt_in_win;

   assign ptr        = bus_rdata[15 -: IDX_W];
   assign tgt        = (bus_be == 2'b11) ? bus_wdata[15 -: IDX_W] : ptr;
   assign lvl_write  = bus_sel && bus_wr && bus_be[0];
   assign ptr_in_win = (int'(ptr) >= FIRST) && (int'(ptr) <= MAX_IRQ);
   assign tgt_in_win = (int'(tgt) >= FIRST) && (int'(tgt) <= MAX_IRQ);

   AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_be[1]) |=> ptr == $past(bus_wdata[15 -: IDX_W])); // R2

   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr && bus_be[1]) |=> $stable(ptr)); // R10

   AST_IDLE_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_write |=> $stable(levels_flat)); // R10

   AST_BLOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_write && !tgt_in_win) |=> $stable(levels_flat)); // R5

   AST_WORD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_write && bus_be[1] && tgt_in_win) |=> bus_rdata[LVL_W-1:0] == $past(bus_wdata[LVL_W-1:0])); // R4

   AST_OUTSIDE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ptr_in_win |-> bus_rdata[LVL_W-1:0] == '0); // R7

   AST_READ_MATCHES_EXPORT: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_in_win |-> bus_rdata[LVL_W-1:0] == levels_flat[int'(ptr)*LVL_W +: LVL_W]); // R9

   AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[7:LVL_W] == '0); // R8

endmodule

bind irq_level_bank irq_level_bank_chk #(
   .IDX_W(IDX_W), .LVL_W(LVL_W), .FIRST(FIRST), .MAX_IRQ(MAX_IRQ)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_sel     (bus_sel),
   .bus_wr      (bus_wr),
   .bus_be      (bus_be),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .levels_flat (levels_flat)
);

// File: tb/irq_level_bank_bench.sv
module irq_level_bank_bench;

   localparam int CLK_PERIOD = 10;
   localparam int MAXI  = 63;
   localparam int FIRST = 12;
   localparam int OUTW  = (MAXI + 1) * 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_sel = 1'b0;
   logic            bus_wr = 1'b0;
   logic [1:0]      bus_be = 2'b00;
   logic [15:0]     bus_wdata = 16'h0;
   logic [15:0]     bus_rdata;
   logic [OUTW-1:0] levels_flat;

   int checks = 0;
   int failures = 0;
   int m_idx;
   int m_lvl[MAXI+1];

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_level_bank u_irq_level_bank (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .levels_flat(levels_flat)
   );

   function automatic bit in_win(int i);
      return (i >= FIRST) && (i <= MAXI);
   endfunction

   task automatic model_reset();
      m_idx = 0;
      for (int n = 0; n <= MAXI; n++) m_lvl[n] = (n < FIRST) ? 0 : 7;
   endtask

   task automatic model_step(bit sel, bit wr, logic [1:0] be, logic [15:0] wd);
      int tgt;
      if (sel && wr) begin
         tgt = (be == 2'b11) ? int'(wd[15:8]) : m_idx;
         if (be[0] && in_win(tgt)) m_lvl[tgt] = int'(wd[2:0]);
         if (be[1]) m_idx = int'(wd[15:8]);
      end
   endtask

   task automatic compare(string req);
      logic [15:0]     exp_rd;
      logic [OUTW-1:0] exp_flat;
      exp_rd = {m_idx[7:0], 5'b0, in_win(m_idx) ? m_lvl[m_idx][2:0] : 3'b000};
      for (int n = 0; n <= MAXI; n++) exp_flat[n*3 +: 3] = m_lvl[n][2:0];
      checks++;
      if (bus_rdata !== exp_rd) begin
         failures++;
         $display("FAIL %s rdata actual=%h expected=%h", req, bus_rdata, exp_rd);
      end
      checks++;
      if (levels_flat !== exp_flat) begin
         failures++;
         $display("FAIL %s levels_flat actual=%h expected=%h", req, levels_flat, exp_flat);
      end
   endtask

   // drive at falling edge, model follows the rising edge, compare at next falling edge
   task automatic access(string req, bit sel, bit wr, logic [1:0] be, logic [15:0] wd);
      bus_sel = sel; bus_wr = wr; bus_be = be; bus_wdata = wd;
      @(posedge clk);
      model_step(sel, wr, be, wd);
      @(negedge clk);
      compare(req);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");                                  // reset state
      access("R10", 1, 0, 2'b11, 16'h14_05);          // read only
      access("R2",  1, 1, 2'b10, 16'h14_05);          // pointer -> 20
      access("R3",  1, 1, 2'b01, 16'h00_03);          // entry 20 = 3
      access("R4",  1, 1, 2'b11, 16'h0D_05);          // entry 13 = 5
      access("R8",  1, 1, 2'b01, 16'h00_FA);          // entry 13 = 2, gap bits ignored
      access("R10", 0, 1, 2'b11, 16'h20_01);          // not selected
      access("R10", 1, 1, 2'b00, 16'h20_01);          // no byte enables
      access("R5",  1, 1, 2'b11, 16'h05_01);          // protected, pointer -> 5
      access("R5",  1, 1, 2'b01, 16'h00_04);          // protected low write
      access("R5",  1, 1, 2'b11, 16'h0B_02);          // index 11
      access("R4",  1, 1, 2'b11, 16'h0C_06);          // index 12 boundary
      access("R4",  1, 1, 2'b11, 16'h3F_00);          // index MAX
      access("R6",  1, 1, 2'b11, 16'h40_02);          // MAX+1
      access("R6",  1, 1, 2'b01, 16'h00_01);          // low write above MAX
      access("R7",  1, 1, 2'b11, 16'hFF_04);          // index 255
      access("R7",  1, 1, 2'b10, 16'h14_00);          // back to 20, read 3
      access("R9",  1, 1, 2'b01, 16'h00_07);
      for (int k = 0; k < 400; k++) begin
         logic [15:0] wd;
         logic [1:0]  be;
         wd = 16'($urandom);
         be = 2'($urandom);
         if (k % 3 == 0) wd[15:8] = 8'(FIRST + int'($urandom % (MAXI - FIRST + 3)) - 1);
         access("R9", ($urandom % 8) != 0, ($urandom % 4) != 0, be, wd);
      end
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      compare("R1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule